// File: doc/BRIEF.md
# Sound Generator Host Register Front End

This block is the host side of a three-voice programmable sound generator. A host drives an 8-bit data bus and a 2-bit function code. The block holds fifteen 8-bit control registers and turns them into decoded fields for the tone, noise and envelope engines. It also owns an 8-bit bidirectional general-purpose port whose direction and output value come from the register file.

The function code is level-sensitive. Whatever the code asks for is carried out on every clock edge for as long as the code is held:

- With the select code held, each new bus value becomes the current register number.
- With the write code held, the current register is reloaded from the bus on every cycle.

A host must therefore return to the idle code between steps. Reads are combinational from the current register. The bus output enable is raised only while the read code is applied.

Top module: `snd_bus_regs`

## Requirements
- R1: The function code is decoded as 00 idle, 01 read, 10 write and 11 select. `bus_oe_o` is 1 only while the code is 01.
- R2: On every clock edge with code 11, the register number is loaded from `bus_i`, so a bus change while 11 is held reselects. The number persists through idle cycles.
- R3: On every clock edge with code 10, `bus_i` is stored into the currently selected register. The fields are decoded as follows:
  - Tone A is {reg1[3:0], reg0}, tone B is {reg3[3:0], reg2} and tone C is {reg5[3:0], reg4}.
  - The noise period is reg6[4:0].
  - The tone disables are reg7[2:0] and the noise disables are reg7[5:3].
  - Volumes A, B and C are reg8, reg9 and reg10, each bits [4:0].
  - The envelope period is {reg12, reg11}.
  - The envelope shape is reg13[3:0].
- R4: Registers 1, 3, 5 and 13 keep only bits 3:0. Registers 6, 8, 9 and 10 keep only bits 4:0. The dropped bits read back as 0.
- R5: With code 01, `bus_o` carries the selected register's stored value in the same cycle.
- R6: When the selected number is 15 or above, writes change no register and reads return 0xFF.
- R7: Register 7 bit 6 drives `gpio_oe_o`, with 1 meaning output. Register 14 drives `gpio_o`.
- R8: A read of register 14 returns the following:
  - `gpio_i` when register 7 bit 6 is 0.
  - The stored register 14 value when register 7 bit 6 is 1.
- R9: `env_restart_o` is 1 for the cycle that follows each clock edge at which a write to register 13 took place. Otherwise it is 0.
- R10: A synchronous active-low reset clears every register and the register number to 0. After reset the port is in input mode and `env_restart_o` is 0.
- R11: Code 00 changes neither the registers nor the register number, whatever the bus does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_i | input | 2 | Function code |
| bus_i | input | 8 | Data bus from the host |
| bus_o | output | 8 | Read data to the host |
| bus_oe_o | output | 1 | Read data output enable |
| gpio_i | input | 8 | General-purpose port pins in |
| gpio_o | output | 8 | General-purpose port output value |
| gpio_oe_o | output | 1 | General-purpose port output enable |
| tone_a_o | output | 12 | Voice A tone period |
| tone_b_o | output | 12 | Voice B tone period |
| tone_c_o | output | 12 | Voice C tone period |
| noise_per_o | output | 5 | Noise period |
| tone_dis_o | output | 3 | Tone disable per voice (bit 0 = A) |
| noise_dis_o | output | 3 | Noise disable per voice (bit 0 = A) |
| vol_a_o | output | 5 | Voice A level and envelope select |
| vol_b_o | output | 5 | Voice B level and envelope select |
| vol_c_o | output | 5 | Voice C level and envelope select |
| env_per_o | output | 16 | Envelope period |
| env_shape_o | output | 4 | Envelope shape |
| env_restart_o | output | 1 | Envelope restart pulse |

## Verification
The assertions check three things on every cycle:
- The output enable stays low outside the read code.
- A restart pulse never appears unless a write was applied on the edge before it.
- The shape and volume fields stay steady through any cycle that was not a write.

The bench's scenarios are needed for the rest:
- The level-sensitive reselect while select is held.
- The field masks.
- Reads beyond register 14.
- The port-direction dependence of register 14 reads.
- The exact one-cycle width of the restart pulse.

// File: rtl/snd_bus_pkg.sv
package snd_bus_pkg;

    localparam int DW       = 8;
    localparam int NUM_REGS = 15;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [IDX_W-1:0] MIX_IDX   = IDX_W'(7);
    localparam logic [IDX_W-1:0] SHAPE_IDX = IDX_W'(13);
    localparam logic [IDX_W-1:0] PORT_IDX  = IDX_W'(14);
    localparam int               DIR_BIT   = 6;

    typedef enum logic [1:0] {
        FN_IDLE   = 2'b00,
        FN_READ   = 2'b01,
        FN_WRITE  = 2'b10,
        FN_SELECT = 2'b11
    } bus_fn_e;

    typedef struct packed {
        logic [DW-1:0]                sel;
        logic [NUM_REGS-1:0][DW-1:0]  regs;
        logic                         restart;
    } regfile_st;

    // bits each register keeps
    function automatic logic [DW-1:0] reg_mask(input int idx);
        case (idx)
            1, 3, 5, 13: reg_mask = DW'(8'h0F);
            6, 8, 9, 10: reg_mask = DW'(8'h1F);
            default:     reg_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/snd_func_decode.sv
module snd_func_decode
    import snd_bus_pkg::*;
(
    input  logic [1:0] func_i,
    output logic       rd_o,
    output logic       wr_o,
    output logic       sel_o
);
    bus_fn_e fn;

    always_comb begin
        fn    = bus_fn_e'(func_i);
        rd_o  = (fn == FN_READ);
        wr_o  = (fn == FN_WRITE);
        sel_o = (fn == FN_SELECT);
    end
endmodule

// File: rtl/snd_regfile.sv
module snd_regfile
    import snd_bus_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_i,
    input  logic                        sel_i,
    input  logic [DW-1:0]               bus_i,
    output logic [DW-1:0]               sel_o,
    output logic [NUM_REGS-1:0][DW-1:0] regs_o,
    output logic                        restart_o
);
    regfile_st st_d, st_q;
    logic [NUM_REGS-1:0] wr_hit;
    logic                sel_ok;

    assign sel_ok = (st_q.sel < DW'(NUM_REGS));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign wr_hit[g] = wr_i && sel_ok && (st_q.sel[IDX_W-1:0] == IDX_W'(g));
    end

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        if (sel_i)
            st_d.sel = bus_i;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_hit[i])
                st_d.regs[i] = bus_i & reg_mask(i);
        end
        if (wr_hit[SHAPE_IDX])
            st_d.restart = 1'b1;
        if (!rst_n)
            st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sel_o     = st_q.sel;
    assign regs_o    = st_q.regs;
    assign restart_o = st_q.restart;
endmodule

// File: rtl/snd_read_mux.sv
module snd_read_mux
    import snd_bus_pkg::*;
(
    input  logic [DW-1:0]               sel_i,
    input  logic [NUM_REGS-1:0][DW-1:0] regs_i,
    input  logic [DW-1:0]               gpio_i,
    output logic [DW-1:0]               rd_data_o
);
    logic port_out;

    always_comb begin
        port_out = regs_i[MIX_IDX][DIR_BIT];
        if (sel_i >= DW'(NUM_REGS))
            rd_data_o = '1;
        else if (sel_i[IDX_W-1:0] == PORT_IDX && !port_out)
            rd_data_o = gpio_i;
        else
            rd_data_o = regs_i[sel_i[IDX_W-1:0]];
    end
endmodule

// File: rtl/snd_bus_regs.sv
module snd_bus_regs
    import snd_bus_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  func_i,
    input  logic [7:0]  bus_i,
    output logic [7:0]  bus_o,
    output logic        bus_oe_o,
    input  logic [7:0]  gpio_i,
    output logic [7:0]  gpio_o,
    output logic        gpio_oe_o,
    output logic [11:0] tone_a_o,
    output logic [11:0] tone_b_o,
    output logic [11:0] tone_c_o,
    output logic [4:0]  noise_per_o,
    output logic [2:0]  tone_dis_o,
    output logic [2:0]  noise_dis_o,
    output logic [4:0]  vol_a_o,
    output logic [4:0]  vol_b_o,
    output logic [4:0]  vol_c_o,
    output logic [15:0] env_per_o,
    output logic [3:0]  env_shape_o,
    output logic        env_restart_o
);
    logic                        rd, wr, sl;
    logic [DW-1:0]               sel;
    logic [NUM_REGS-1:0][DW-1:0] regs;

    snd_func_decode u_dec (
        .func_i (func_i),
        .rd_o   (rd),
        .wr_o   (wr),
        .sel_o  (sl)
    );

    snd_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .sel_i     (sl),
        .bus_i     (bus_i),
        .sel_o     (sel),
        .regs_o    (regs),
        .restart_o (env_restart_o)
    );

    snd_read_mux u_rd (
        .sel_i     (sel),
        .regs_i    (regs),
        .gpio_i    (gpio_i),
        .rd_data_o (bus_o)
    );

    assign bus_oe_o    = rd;
    assign gpio_o      = regs[PORT_IDX];
    assign gpio_oe_o   = regs[MIX_IDX][DIR_BIT];
    assign tone_a_o    = {regs[1][3:0], regs[0]};
    assign tone_b_o    = {regs[3][3:0], regs[2]};
    assign tone_c_o    = {regs[5][3:0], regs[4]};
    assign noise_per_o = regs[6][4:0];
    assign tone_dis_o  = regs[MIX_IDX][2:0];
    assign noise_dis_o = regs[MIX_IDX][5:3];
    assign vol_a_o     = regs[8][4:0];
    assign vol_b_o     = regs[9][4:0];
    assign vol_c_o     = regs[10][4:0];
    assign env_per_o   = {regs[12], regs[11]};
    assign env_shape_o = regs[SHAPE_IDX][3:0];
endmodule

// File: rtl/snd_bus_regs_chk.sv
module snd_bus_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  func_i,
    input logic        bus_oe_o,
    input logic        gpio_oe_o,
    input logic [4:0]  vol_a_o,
    input logic [15:0] env_per_o,
    input logic [3:0]  env_shape_o,
    input logic        env_restart_o
);
    AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (func_i != 2'b01) |-> !bus_oe_o); // R1

    AST_RESTART_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart_o |-> ($past(func_i) == 2'b10)); // R9

    AST_SHAPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_i) != 2'b10) |-> $stable(env_shape_o)); // R11

    AST_VOL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(func_i) != 2'b10) |-> $stable(vol_a_o)); // R3

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!gpio_oe_o && env_per_o == 16'h0 && !env_restart_o)); // R10
endmodule

bind snd_bus_regs snd_bus_regs_chk u_chk (.*);

// File: tb/snd_bus_regs_tb.sv
`timescale 1ns/1ps
module snd_bus_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  func_r = 2'b00;
    logic [7:0]  bus_r = 8'h00;
    logic [7:0]  gpio_r = 8'h00;
    logic [7:0]  bus_o, gpio_o;
    logic        bus_oe_o, gpio_oe_o, env_restart_o;
    logic [11:0] tone_a_o, tone_b_o, tone_c_o;
    logic [4:0]  noise_per_o, vol_a_o, vol_b_o, vol_c_o;
    logic [2:0]  tone_dis_o, noise_dis_o;
    logic [15:0] env_per_o;
    logic [3:0]  env_shape_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    snd_bus_regs u_dut (
        .clk(clk), .rst_n(rst_n), .func_i(func_r), .bus_i(bus_r),
        .bus_o(bus_o), .bus_oe_o(bus_oe_o), .gpio_i(gpio_r),
        .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o),
        .tone_a_o(tone_a_o), .tone_b_o(tone_b_o), .tone_c_o(tone_c_o),
        .noise_per_o(noise_per_o), .tone_dis_o(tone_dis_o),
        .noise_dis_o(noise_dis_o), .vol_a_o(vol_a_o), .vol_b_o(vol_b_o),
        .vol_c_o(vol_c_o), .env_per_o(env_per_o),
        .env_shape_o(env_shape_o), .env_restart_o(env_restart_o)
    );

    // {func, bus, expected read data}
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {2'b11, 8'h00, 8'h00}, {2'b00, 8'h77, 8'h00}, {2'b10, 8'h5A, 8'h00},
        {2'b00, 8'h00, 8'h00}, {2'b01, 8'h00, 8'h5A},
        {2'b11, 8'h01, 8'h00}, {2'b10, 8'hF7, 8'h00}, {2'b01, 8'h00, 8'h07},
        {2'b11, 8'h06, 8'h00}, {2'b10, 8'hFF, 8'h00}, {2'b01, 8'h00, 8'h1F},
        {2'b11, 8'h0D, 8'h00}, {2'b10, 8'hFA, 8'h00}, {2'b01, 8'h00, 8'h0A},
        {2'b11, 8'h0C, 8'h00}, {2'b10, 8'h81, 8'h00}, {2'b01, 8'h00, 8'h81},
        {2'b11, 8'h0F, 8'h00}, {2'b10, 8'h33, 8'h00}, {2'b01, 8'h00, 8'hFF},
        {2'b11, 8'h09, 8'h00}, {2'b10, 8'hFF, 8'h00}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at the falling edge, let it be registered, sample after
    task automatic step(input logic [1:0] f, input logic [7:0] d);
        @(negedge clk);
        func_r = f;
        bus_r  = d;
        @(posedge clk);
        #1;
    endtask

    task automatic rd_chk(input logic [7:0] exp, input string req);
        @(negedge clk);
        func_r = 2'b01;
        #1;
        chk(bus_oe_o && bus_o == exp, req, {23'd0, bus_oe_o, bus_o}, {24'd1, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(!gpio_oe_o && env_per_o == 0 && tone_a_o == 0 && !env_restart_o,
            "R10", {gpio_oe_o, env_per_o}, 0);
        rst_n = 1'b1;
        step(2'b00, 8'h00);
        rd_chk(8'h00, "R10");

        // table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            func_r = VEC[i][17:16];
            bus_r  = VEC[i][15:8];
            #1;
            if (VEC[i][17:16] == 2'b01)
                chk(bus_oe_o && bus_o == VEC[i][7:0], "R5", {bus_oe_o, bus_o},
                    {1'b1, VEC[i][7:0]});
            else
                chk(!bus_oe_o, "R1", bus_oe_o, 0);
        end
        step(2'b00, 8'h00);

        // R3 field decode, R4 masks visible in fields
        chk(tone_a_o == 12'h75A, "R3", tone_a_o, 12'h75A);
        chk(noise_per_o == 5'h1F, "R4", noise_per_o, 5'h1F);
        chk(env_per_o == 16'h8100, "R3", env_per_o, 16'h8100);
        chk(env_shape_o == 4'hA, "R4", env_shape_o, 4'hA);
        chk(vol_b_o == 5'h1F, "R4", vol_b_o, 5'h1F);

        // R2 level reselect: hold select while the bus changes 2 -> 4
        step(2'b11, 8'h02);
        step(2'b11, 8'h04);
        step(2'b10, 8'h12);
        step(2'b00, 8'h00);
        rd_chk(8'h12, "R2");
        chk(tone_c_o == 12'h012 && tone_b_o == 12'h000, "R2", tone_b_o, 0);

        // R11 idle with moving bus changes nothing
        step(2'b00, 8'h09);
        step(2'b00, 8'hEE);
        rd_chk(8'h12, "R11");
        chk(tone_c_o == 12'h012 && env_per_o == 16'h8100, "R11", tone_c_o, 12'h012);

        // R9 restart pulse
        step(2'b11, 8'h0D);
        chk(!env_restart_o, "R9", env_restart_o, 0);
        step(2'b10, 8'h0E);
        chk(env_restart_o && env_shape_o == 4'hE, "R9", {env_restart_o, env_shape_o}, 5'h1E);
        step(2'b00, 8'h00);
        chk(!env_restart_o, "R9", env_restart_o, 0);
        step(2'b11, 8'h0B);
        step(2'b10, 8'h44);
        chk(!env_restart_o && env_per_o == 16'h8144, "R9", {env_restart_o, env_per_o},
            17'h08144);

        // R6 write beyond range ignored
        step(2'b11, 8'hFE);
        step(2'b10, 8'h99);
        step(2'b00, 8'h00);
        chk(env_per_o == 16'h8144 && env_shape_o == 4'hE && tone_c_o == 12'h012,
            "R6", env_per_o, 16'h8144);
        rd_chk(8'hFF, "R6");

        // R7 R8 general-purpose port
        gpio_r = 8'hA5;
        step(2'b11, 8'h0E);
        step(2'b10, 8'h3C);
        step(2'b00, 8'h00);
        chk(gpio_o == 8'h3C && !gpio_oe_o, "R7", {gpio_oe_o, gpio_o}, 9'h03C);
        rd_chk(8'hA5, "R8");
        step(2'b11, 8'h07);
        step(2'b10, 8'h6B);
        step(2'b00, 8'h00);
        chk(gpio_oe_o && tone_dis_o == 3'b011 && noise_dis_o == 3'b101, "R7",
            {gpio_oe_o, noise_dis_o, tone_dis_o}, 7'b1101011);
        step(2'b11, 8'h0E);
        step(2'b00, 8'h00);
        rd_chk(8'h3C, "R8");

        // R10 reset mid-run
        @(negedge clk);
        func_r = 2'b00;
        rst_n  = 1'b0;
        @(posedge clk);
        #1;
        chk(!gpio_oe_o && env_per_o == 0 && tone_c_o == 0 && gpio_o == 0, "R10",
            env_per_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk(8'h00, "R10");
        step(2'b00, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule